// File: doc/BRIEF.md
# Interrupt Status and Error Latch

This block holds the interrupt status byte and the sticky error byte of a peripheral controller and drives its active-low interrupt request. Neighbouring logic raises one-cycle pulses: a keypad event, the end of a script on one of three PWM channels, or one of several error causes. Each pulse sets its bit, and the bits stay set until software clears them. The interrupt line is low whenever any status bit is set.

Software reads status with a read-status strobe, which returns the byte and then clears it. After reset, a not-initialised bit is set. While that bit is set, reading status does not clear it. Only a configuration write clears the not-initialised bit, and that write clears the whole status byte. The error byte is returned by a read-error strobe and is never cleared by a read. A new event that arrives in the same cycle as a clear is kept.

Top module: `irq_status_latch`

## Requirements
- R1: After reset, status is 0x10 (only bit 4, not-initialised, set), error is 0x00 and irq_n_o is low.
- R2: A one-cycle pulse on key_evt_i sets status bit 0. A pulse on pwm_end_i[k] sets status bit 5+k. Bits accumulate and stay set until a clear.
- R3: The error byte takes err_cause_i bits 0 (bad parameter), 1 (unknown command), 2 (key overrun) and 6 (overflow) by OR at the rising edge. Pulses on the other err_cause_i bits change neither byte.
- R4: Any accepted error cause sets status bit 3 at the same edge as the error bit.
- R5: irq_n_o is low exactly when the status byte is non-zero.
- R6: rd_status_i drives the current status onto rd_data_o in the same cycle. At the next edge, status is cleared to zero if bit 4 is clear, and is left unchanged if bit 4 is set.
- R7: cfg_wr_i clears the whole status byte at the next edge, bit 4 included, whatever its contents.
- R8: The error byte is returned on rd_data_o while rd_error_i is high (with rd_status_i low). It is not cleared by reads or by configuration writes, only by reset.
- R9: A set pulse in the same cycle as a clear, from a status read or a configuration write, leaves its bit set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_evt_i | input | 1 | Keypad event pulse |
| pwm_end_i | input | 3 | Per-channel PWM end pulses |
| err_cause_i | input | 8 | Error cause pulses, one bit per cause |
| cfg_wr_i | input | 1 | Configuration write strobe |
| rd_status_i | input | 1 | Read-status strobe |
| rd_error_i | input | 1 | Read-error strobe |
| rd_data_o | output | 8 | Read data: status if rd_status_i, else error if rd_error_i, else 0 |
| status_o | output | 8 | Current status byte |
| error_o | output | 8 | Current error byte |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench repeats status reads while the not-initialised bit is set. A design that ignored the guard would clear the bit and release the interrupt before configuration. It pulses undefined error-cause bits: a design that did not mask them would grow the error byte or raise status bit 3. It issues reads and configuration writes together with new events. A design that let the clear win would lose an interrupt. It also reads the error byte repeatedly to catch a design that cleared it on read.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int ST_W      = 8;
  localparam int ER_W      = 8;
  localparam int NUM_PWM   = 3;
  localparam int ST_KEY    = 0;
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  localparam int ST_PWM0   = 5;
  localparam logic [ER_W-1:0] ER_VALID = 8'h47;
  localparam logic [ST_W-1:0] ST_RESET = ST_W'(1) << ST_NOINIT;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_latch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_evt_i,
  input  logic [NUM_PWM-1:0] pwm_end_i,
  input  logic               err_evt_i,
  input  logic               cfg_wr_i,
  input  logic               rd_i,
  output logic [ST_W-1:0]    status_o
);
  logic [ST_W-1:0] status_q, status_d, set_vec;
  logic            clr_en, upd_en;

  always_comb begin
    set_vec = '0;
    set_vec[ST_KEY] = key_evt_i;
    set_vec[ST_ERR] = err_evt_i;
    for (int k = 0; k < NUM_PWM; k++) begin
      set_vec[ST_PWM0 + k] = pwm_end_i[k];
    end
  end

  always_comb begin
    clr_en   = cfg_wr_i | (rd_i & ~status_q[ST_NOINIT]);
    status_d = (clr_en ? '0 : status_q) | set_vec;
    upd_en   = clr_en | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= ST_RESET;
    else if (upd_en) status_q <= status_d;
  end

  assign status_o = status_q;

  assert_noinit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && status_q[ST_NOINIT] && !cfg_wr_i) |=> ((status_q & $past(status_q)) == $past(status_q)));
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !status_q[ST_NOINIT] && !key_evt_i && !err_evt_i && pwm_end_i == '0) |=> (status_q == '0));
  assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> !status_q[ST_NOINIT]);
  assert_event_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt_i |=> status_q[ST_KEY]);
  assert_err_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> status_q[ST_ERR]);
endmodule

// File: rtl/irq_error_reg.sv
module irq_error_reg
  import irq_latch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ER_W-1:0] err_cause_i,
  output logic [ER_W-1:0] error_o,
  output logic            err_evt_o
);
  logic [ER_W-1:0] error_q, error_d, accepted;
  logic            upd_en;

  always_comb begin
    accepted = err_cause_i & ER_VALID;
    upd_en   = |accepted;
    error_d  = error_q | accepted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      error_q <= '0;
    else if (upd_en) error_q <= error_d;
  end

  assign error_o   = error_q;
  assign err_evt_o = upd_en;

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((error_q & $past(error_q)) == $past(error_q)));
  assert_valid_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((error_q & ~ER_VALID) == '0));
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
  import irq_latch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_evt_i,
  input  logic [NUM_PWM-1:0] pwm_end_i,
  input  logic [ER_W-1:0]    err_cause_i,
  input  logic               cfg_wr_i,
  input  logic               rd_status_i,
  input  logic               rd_error_i,
  output logic [ST_W-1:0]    rd_data_o,
  output logic [ST_W-1:0]    status_o,
  output logic [ER_W-1:0]    error_o,
  output logic               irq_n_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       err_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irq_error_reg u_err (
    .clk(clk), .rst_n(rst_sync_n), .err_cause_i(err_cause_i),
    .error_o(error_o), .err_evt_o(err_evt)
  );

  irq_status_reg u_st (
    .clk(clk), .rst_n(rst_sync_n), .key_evt_i(key_evt_i), .pwm_end_i(pwm_end_i),
    .err_evt_i(err_evt), .cfg_wr_i(cfg_wr_i), .rd_i(rd_status_i), .status_o(status_o)
  );

  assign irq_n_o = ~(|status_o);

  always_comb begin
    if (rd_status_i)     rd_data_o = status_o;
    else if (rd_error_i) rd_data_o = ST_W'(error_o);
    else                 rd_data_o = '0;
  end

  assert_key_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_evt_i |=> !irq_n_o);
  assert_rderr_keeps_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_error_i || cfg_wr_i) |=> ((error_o & $past(error_o)) == $past(error_o)));
endmodule

// File: tb/irq_status_latch_bench.sv
module irq_status_latch_bench;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       key = 0, cfg = 0, rds = 0, rde = 0;
  logic [2:0] pwm = 0;
  logic [7:0] cause = 0;
  logic [7:0] rd_data, status, error;
  logic       irq_n;

  int errors = 0, checks = 0;
  int m_st = 8'h10, m_er = 0;
  bit run = 0, done = 0;
  string cur_tag = "R1";

  irq_status_latch u_irq_status_latch (
    .clk(clk), .rst_n(rst_n), .key_evt_i(key), .pwm_end_i(pwm), .err_cause_i(cause),
    .cfg_wr_i(cfg), .rd_status_i(rds), .rd_error_i(rde),
    .rd_data_o(rd_data), .status_o(status), .error_o(error), .irq_n_o(irq_n)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%02h exp=%02h", tag, what, act, exp);
    end
  endtask

  // reference model: update on each rising edge from the sampled inputs
  always @(posedge clk) if (run) begin
    int clr, sets, acc;
    acc  = cause & 8'h47;
    sets = (key ? 1 : 0) | (int'(pwm) << 5) | ((acc != 0) ? 8'h08 : 0);
    clr  = (cfg || (rds && ((m_st & 8'h10) == 0))) ? 1 : 0;
    m_st = (clr ? 0 : m_st) | sets;
    m_er = m_er | acc;
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (run) begin
    chk(cur_tag, "status", int'(status), m_st);
    chk(cur_tag, "error", int'(error), m_er);
    chk("R5", "irq_n", int'(irq_n), (m_st != 0) ? 0 : 1);
  end

  task automatic cyc(input string tag, input bit k, input logic [2:0] p, input logic [7:0] c,
                     input bit w, input bit rs, input bit re);
    int exp_rd;
    @(negedge clk); #1;
    key = k; pwm = p; cause = c; cfg = w; rds = rs; rde = re;
    cur_tag = tag;
    #1;
    exp_rd = rs ? m_st : (re ? m_er : 0);
    chk(tag, "rd_data", int'(rd_data), exp_rd);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 3'b000, 8'h00, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #2 run = 1;
    idle("R1");
    // reads while not initialised keep bit 4
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 0);
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 0);
    cyc("R2", 1, 3'b000, 8'h00, 0, 0, 0);
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 0);
    // configuration write clears everything
    cyc("R7", 0, 3'b000, 8'h00, 1, 0, 0);
    idle("R5");
    // key event then read clear
    cyc("R2", 1, 3'b000, 8'h00, 0, 0, 0);
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 0);
    idle("R6");
    // pwm channel ends accumulate
    cyc("R2", 0, 3'b001, 8'h00, 0, 0, 0);
    cyc("R2", 0, 3'b010, 8'h00, 0, 0, 0);
    cyc("R2", 0, 3'b100, 8'h00, 0, 0, 0);
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 0);
    // undefined error causes ignored
    cyc("R3", 0, 3'b000, 8'hB8, 0, 0, 0);
    idle("R3");
    // each defined error cause
    cyc("R4", 0, 3'b000, 8'h01, 0, 0, 0);
    cyc("R3", 0, 3'b000, 8'h02, 0, 0, 1);
    cyc("R3", 0, 3'b000, 8'h04, 0, 1, 0);
    cyc("R4", 0, 3'b000, 8'h40, 0, 0, 0);
    // error reads and config write keep the error byte
    cyc("R8", 0, 3'b000, 8'h00, 0, 0, 1);
    cyc("R8", 0, 3'b000, 8'h00, 0, 0, 1);
    cyc("R8", 0, 3'b000, 8'h00, 1, 0, 0);
    cyc("R8", 0, 3'b000, 8'h00, 0, 0, 1);
    // events colliding with clears
    cyc("R9", 1, 3'b000, 8'h00, 0, 1, 0);
    idle("R9");
    cyc("R9", 0, 3'b100, 8'h01, 1, 0, 0);
    idle("R9");
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 1);
    idle("R6");
    // read with no set pending after collisions
    cyc("R9", 1, 3'b011, 8'h00, 1, 1, 0);
    cyc("R6", 0, 3'b000, 8'h00, 0, 1, 0);
    idle("R5");
    idle("R5");
    @(negedge clk); #2 run = 0;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule